// File: doc/BRIEF.md
# Temperature threshold alarm unit

This block watches a stream of temperature codes, each marked by a valid strobe, and keeps four sticky alarm status bits: high level, low level, rising edge and falling edge. Each alarm compares the incoming code against its own pair of thresholds. The two level alarms use a hysteresis band and keep their condition active until the code returns to the normal side of that band. The two edge alarms must be re-armed by a separate hysteresis threshold before they can fire again.

Software configures the threshold pairs, two mode enables (one for the level pair, one for the edge pair), an interrupt enable vector and a clear vector. Clear bits are level inputs, not pulses. A level status bit clears only while its clear bit is high and its condition has gone inactive. An edge status bit clears on the clear bit alone. The interrupt line is the OR of the status bits masked by their enables.

Top module: `temp_alarm_unit`

## Requirements
- R1: Alarm bit positions in the enable, clear and status vectors are 0 high level, 1 low level, 2 rising edge, 3 falling edge. The high and low threshold words carry the upper threshold in bits [CODE_W-1:0] and the lower threshold in bits [2*CODE_W-1:CODE_W]. The rising and falling words carry the alarm code in bits [CODE_W-1:0] and the hysteresis code in bits [2*CODE_W-1:CODE_W].
- R2: With the level mode on, a valid sample at or above the high word's upper threshold sets status bit 0 at that clock edge. The high condition then stays active until a valid sample is at or below the lower threshold.
- R3: With the level mode on, a valid sample at or below the low word's lower threshold sets status bit 1 at that clock edge. The low condition then stays active until a valid sample is at or above the upper threshold. If a sample meets both tests, the trip test wins.
- R4: A level status bit clears at a clock edge where its clear bit is high and its condition, as left by earlier samples, is inactive. While the condition is active the bit stays set, even with the clear bit held high. A new trip in the same cycle wins over the clear.
- R5: The rising alarm becomes armed on a valid sample at or below its hysteresis code. An armed valid sample at or above its alarm code sets status bit 2 and disarms the alarm, so it fires once per arming.
- R6: The falling alarm becomes armed on a valid sample at or above its hysteresis code. An armed valid sample at or below its alarm code sets status bit 3 and disarms the alarm.
- R7: An edge status bit is zero after any clock edge at which its clear bit was high, whatever the code. A firing in that cycle is lost, and its arming is still used up.
- R8: Cycles with the valid strobe low change no condition, arming or status bit.
- R9: While a pair's mode enable is low, that pair sets no status bit and its conditions or arming are held at zero. Status bits already set stay set.
- R10: irq_out is high exactly when some status bit and its enable bit are both high. Status bits latch whether or not their enable is set.
- R11: Reset makes all status bits, conditions and arming zero, and drives irq_out low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_code | input | CODE_W (12) | Temperature code |
| sample_valid | input | 1 | Marks sample_code as a new sample |
| level_mode_en | input | 1 | Turns on the high/low level pair |
| edge_mode_en | input | 1 | Turns on the rising/falling edge pair |
| high_thr | input | 2*CODE_W (24) | High alarm thresholds: upper [11:0], lower [23:12] |
| low_thr | input | 2*CODE_W (24) | Low alarm thresholds: upper [11:0], lower [23:12] |
| rise_thr | input | 2*CODE_W (24) | Rising alarm: alarm [11:0], hysteresis [23:12] |
| fall_thr | input | 2*CODE_W (24) | Falling alarm: alarm [11:0], hysteresis [23:12] |
| irq_en | input | 4 | Interrupt enable per alarm |
| irq_clr | input | 4 | Level-held clear per alarm |
| irq_status | output | 4 | Sticky alarm status |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is a level alarm whose clear bit is held while its condition is still active, followed by a sample that leaves the band. The clear must then take effect only one edge later, from the updated condition. A directed sequence walks the code through the band with the clear held, and checks a rising alarm that has already fired and not yet re-armed. A pseudo-random walk over a 4-bit code then runs against an arithmetic model in the bench. It uses several threshold sets and random valid, clear, enable and mode changes, so that sets, clears and re-arms collide in the same cycle.

// File: rtl/talarm_pkg.sv
package talarm_pkg;
   typedef enum int unsigned {
      ALM_HIGH = 0,
      ALM_LOW  = 1,
      ALM_RISE = 2,
      ALM_FALL = 3
   } alarm_idx_e;

   localparam int unsigned NUM_ALARMS = 4;
   localparam int unsigned NUM_LEVEL  = 2;
   localparam int unsigned NUM_EDGE   = 2;
endpackage

// File: rtl/talarm_level_det.sv
module talarm_level_det #(
   parameter int unsigned CODE_W    = 12,
   parameter bit          HIGH_SIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic              valid,
   input  logic              mode_en,
   input  logic [CODE_W-1:0] upper,
   input  logic [CODE_W-1:0] lower,
   input  logic              clr,
   output logic              status
);
   logic trip, release_c, set_evt, cond_q;

   generate
      if (HIGH_SIDE) begin : g_high
         assign trip      = (code >= upper);
         assign release_c = (code <= lower);
      end else begin : g_low
         assign trip      = (code <= lower);
         assign release_c = (code >= upper);
      end
   endgenerate

   assign set_evt = mode_en & valid & trip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
      end else if (!mode_en) begin
         cond_q <= 1'b0;
      end else if (valid && trip) begin
         cond_q <= 1'b1;
      end else if (valid && release_c) begin
         cond_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= 1'b0;
      end else if (set_evt) begin
         status <= 1'b1;
      end else if (clr && !cond_q) begin
         status <= 1'b0;
      end
   end
endmodule

// File: rtl/talarm_edge_det.sv
module talarm_edge_det #(
   parameter int unsigned CODE_W = 12,
   parameter bit          RISING = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic              valid,
   input  logic              mode_en,
   input  logic [CODE_W-1:0] alarm_thr,
   input  logic [CODE_W-1:0] hyst_thr,
   input  logic              clr,
   output logic              status
);
   logic reach, rearm, fire, armed_q;

   generate
      if (RISING) begin : g_rise
         assign reach = (code >= alarm_thr);
         assign rearm = (code <= hyst_thr);
      end else begin : g_fall
         assign reach = (code <= alarm_thr);
         assign rearm = (code >= hyst_thr);
      end
   endgenerate

   assign fire = mode_en & valid & armed_q & reach;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (!mode_en || fire) begin
         armed_q <= 1'b0;
      end else if (valid && rearm) begin
         armed_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= 1'b0;
      end else if (clr) begin
         status <= 1'b0;
      end else if (fire) begin
         status <= 1'b1;
      end
   end
endmodule

// File: rtl/temp_alarm_unit.sv
module temp_alarm_unit
   import talarm_pkg::*;
#(
   parameter int unsigned CODE_W = 12,
   localparam int unsigned FIELD_W = 2 * CODE_W,
   localparam int unsigned NA      = NUM_ALARMS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CODE_W-1:0]  sample_code,
   input  logic               sample_valid,
   input  logic               level_mode_en,
   input  logic               edge_mode_en,
   input  logic [FIELD_W-1:0] high_thr,
   input  logic [FIELD_W-1:0] low_thr,
   input  logic [FIELD_W-1:0] rise_thr,
   input  logic [FIELD_W-1:0] fall_thr,
   input  logic [NA-1:0]      irq_en,
   input  logic [NA-1:0]      irq_clr,
   output logic [NA-1:0]      irq_status,
   output logic               irq_out
);
   generate
      if (CODE_W < 2 || CODE_W > 24) begin : g_bad_width
         $error("temp_alarm_unit: CODE_W out of range");
      end
   endgenerate

   logic [FIELD_W-1:0] lvl_thr  [NUM_LEVEL];
   logic [FIELD_W-1:0] edge_thr [NUM_EDGE];

   assign lvl_thr[0]  = high_thr;
   assign lvl_thr[1]  = low_thr;
   assign edge_thr[0] = rise_thr;
   assign edge_thr[1] = fall_thr;

   generate
      for (genvar g = 0; g < NUM_LEVEL; g++) begin : g_level
         talarm_level_det #(
            .CODE_W    (CODE_W),
            .HIGH_SIDE (g == 0)
         ) u_lvl (
            .clk     (clk),
            .rst_n   (rst_n),
            .code    (sample_code),
            .valid   (sample_valid),
            .mode_en (level_mode_en),
            .upper   (lvl_thr[g][CODE_W-1:0]),
            .lower   (lvl_thr[g][FIELD_W-1:CODE_W]),
            .clr     (irq_clr[int'(ALM_HIGH) + g]),
            .status  (irq_status[int'(ALM_HIGH) + g])
         );
      end
      for (genvar g = 0; g < NUM_EDGE; g++) begin : g_edge
         talarm_edge_det #(
            .CODE_W (CODE_W),
            .RISING (g == 0)
         ) u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .code      (sample_code),
            .valid     (sample_valid),
            .mode_en   (edge_mode_en),
            .alarm_thr (edge_thr[g][CODE_W-1:0]),
            .hyst_thr  (edge_thr[g][FIELD_W-1:CODE_W]),
            .clr       (irq_clr[int'(ALM_RISE) + g]),
            .status    (irq_status[int'(ALM_RISE) + g])
         );
      end
   endgenerate

   assign irq_out = |(irq_status & irq_en);
endmodule

module talarm_checker #(
   parameter int unsigned NA = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sample_valid,
   input logic          level_mode_en,
   input logic          edge_mode_en,
   input logic [NA-1:0] irq_clr,
   input logic [NA-1:0] irq_status,
   input logic          irq_out
);
   // R11: one edge after reset is seen, every status bit and the line are low
   assert_reset_clear_R11: assert property (@(posedge clk)
      !rst_n |=> (irq_status == '0) && !irq_out);

   // R4: a set level bit holds while its clear is low
   assert_high_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_status[0] && !irq_clr[0] |=> irq_status[0]);
   assert_low_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_status[1] && !irq_clr[1] |=> irq_status[1]);

   // R7: edge clear wins over everything
   assert_rise_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr[2] |=> !irq_status[2]);
   assert_fall_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr[3] |=> !irq_status[3]);

   // R8: no new status bit without a valid sample
   assert_no_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |=> (irq_status & ~$past(irq_status)) == '0);

   // R9: a pair with its mode off sets nothing
   assert_level_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !level_mode_en |=> (irq_status[1:0] & ~$past(irq_status[1:0])) == 2'b00);
   assert_edge_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_mode_en |=> (irq_status[3:2] & ~$past(irq_status[3:2])) == 2'b00);

   // R10: the line never rises with all status low
   assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (irq_status != '0));
endmodule

bind temp_alarm_unit talarm_checker #(.NA(NA)) u_talarm_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sample_valid  (sample_valid),
   .level_mode_en (level_mode_en),
   .edge_mode_en  (edge_mode_en),
   .irq_clr       (irq_clr),
   .irq_status    (irq_status),
   .irq_out       (irq_out)
);

// File: tb/tb_temp_alarm_unit.sv
`timescale 1ns/1ps
module tb_temp_alarm_unit;
   localparam int W = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [W-1:0]   sample_code = '0;
   logic           sample_valid = 1'b0;
   logic           level_mode_en = 1'b0;
   logic           edge_mode_en = 1'b0;
   logic [2*W-1:0] high_thr = '0, low_thr = '0, rise_thr = '0, fall_thr = '0;
   logic [3:0]     irq_en = '0, irq_clr = '0;
   logic [3:0]     irq_status;
   logic           irq_out;

   int n_chk = 0, n_fail = 0;
   logic [3:0] m_st = '0;
   logic m_ch = 0, m_cl = 0, m_ar = 0, m_af = 0;

   always #2 clk = ~clk;

   temp_alarm_unit #(.CODE_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .sample_code(sample_code), .sample_valid(sample_valid),
      .level_mode_en(level_mode_en), .edge_mode_en(edge_mode_en),
      .high_thr(high_thr), .low_thr(low_thr), .rise_thr(rise_thr), .fall_thr(fall_thr),
      .irq_en(irq_en), .irq_clr(irq_clr), .irq_status(irq_status), .irq_out(irq_out));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Model of one clock edge, written from the requirements
   function automatic void model_edge(input logic [W-1:0] c, input logic v);
      logic [W-1:0] hu, hl, lu, ll, ra, rh, fa, fh;
      logic s0, s1, fr, ff;
      logic [3:0] n;
      hu = high_thr[W-1:0]; hl = high_thr[2*W-1:W];
      lu = low_thr[W-1:0];  ll = low_thr[2*W-1:W];
      ra = rise_thr[W-1:0]; rh = rise_thr[2*W-1:W];
      fa = fall_thr[W-1:0]; fh = fall_thr[2*W-1:W];
      s0 = level_mode_en && v && (c >= hu);
      s1 = level_mode_en && v && (c <= ll);
      fr = edge_mode_en && v && m_ar && (c >= ra);
      ff = edge_mode_en && v && m_af && (c <= fa);
      n = m_st;
      if (s0) n[0] = 1'b1; else if (irq_clr[0] && !m_ch) n[0] = 1'b0;
      if (s1) n[1] = 1'b1; else if (irq_clr[1] && !m_cl) n[1] = 1'b0;
      if (irq_clr[2]) n[2] = 1'b0; else if (fr) n[2] = 1'b1;
      if (irq_clr[3]) n[3] = 1'b0; else if (ff) n[3] = 1'b1;
      m_st = n;
      if (!level_mode_en) begin m_ch = 0; m_cl = 0; end
      else if (v) begin
         if (c >= hu) m_ch = 1; else if (c <= hl) m_ch = 0;
         if (c <= ll) m_cl = 1; else if (c >= lu) m_cl = 0;
      end
      if (!edge_mode_en || fr) m_ar = 0; else if (v && c <= rh) m_ar = 1;
      if (!edge_mode_en || ff) m_af = 0; else if (v && c >= fh) m_af = 1;
   endfunction

   task automatic step(input logic [W-1:0] c, input logic v);
      model_edge(c, v);
      sample_code = c;
      sample_valid = v;
      @(negedge clk);
      chk("model status R2 R3 R5 R6", {28'd0, irq_status}, {28'd0, m_st});
      chk("model line R10", {31'd0, irq_out}, {31'd0, |(m_st & irq_en)});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [31:0] s;
      high_thr = {4'd5, 4'd10}; low_thr = {4'd5, 4'd10};
      rise_thr = {4'd4, 4'd11}; fall_thr = {4'd12, 4'd3};
      irq_en = 4'hF;
      repeat (3) @(negedge clk);
      chk("R11 reset status", {28'd0, irq_status}, 0);
      chk("R11 reset line", {31'd0, irq_out}, 0);
      rst_n = 1'b1;
      level_mode_en = 1; edge_mode_en = 1;
      step(4'd7, 1);
      chk("R1 no alarm mid band", {28'd0, irq_status}, 0);
      step(4'd10, 1);
      chk("R2 R1 high at upper", {28'd0, irq_status}, 32'h1);
      irq_clr[0] = 1;
      step(4'd6, 1);
      chk("R4 held while active", {31'd0, irq_status[0]}, 1);
      step(4'd5, 1);
      chk("R4 clear uses old condition", {31'd0, irq_status[0]}, 1);
      chk("R3 low at lower", {31'd0, irq_status[1]}, 1);
      step(4'd0, 0);
      chk("R4 cleared after release", {31'd0, irq_status[0]}, 0);
      irq_clr[0] = 0;
      step(4'd15, 0);
      chk("R8 invalid sample ignored", {28'd0, irq_status}, 32'h2);
      irq_en = 4'b0001;
      step(4'd15, 0);
      chk("R10 masked line", {31'd0, irq_out}, 0);
      chk("R10 status latched masked", {31'd0, irq_status[1]}, 1);
      irq_en = 4'hF;
      step(4'd3, 1);
      step(4'd11, 1);
      chk("R5 rising fires", {31'd0, irq_status[2]}, 1);
      irq_clr[2] = 1;
      step(4'd11, 0);
      chk("R7 edge clear", {31'd0, irq_status[2]}, 0);
      step(4'd12, 1);
      irq_clr[2] = 0;
      step(4'd2, 1);
      chk("R6 falling fires", {31'd0, irq_status[3]}, 1);
      step(4'd14, 1);
      chk("R5 rearmed fires again", {31'd0, irq_status[2]}, 1);
      irq_clr[2] = 1;
      step(4'd0, 0);
      irq_clr[2] = 0;
      step(4'd15, 1);
      chk("R5 fires once per arming", {31'd0, irq_status[2]}, 0);
      step(4'd0, 1);
      irq_clr[2] = 1;
      step(4'd12, 1);
      chk("R7 clear blocks firing", {31'd0, irq_status[2]}, 0);
      irq_clr[2] = 0;
      step(4'd15, 1);
      chk("R7 arming consumed", {31'd0, irq_status[2]}, 0);
      level_mode_en = 0;
      irq_clr = 4'hF;
      step(4'd0, 0);
      step(4'd0, 0);
      irq_clr = 4'h0;
      chk("R9 R4 all cleared", {28'd0, irq_status}, 0);
      step(4'd15, 1);
      chk("R9 level off no set", {31'd0, irq_status[0]}, 0);
      edge_mode_en = 0;
      step(4'd0, 1);
      edge_mode_en = 1;
      step(4'd15, 1);
      chk("R9 edge off no arming", {31'd0, irq_status[2]}, 0);
      level_mode_en = 1;

      s = 32'h1234_5678;
      for (int cfg = 0; cfg < 4; cfg++) begin
         case (cfg)
            0: begin high_thr = {4'd5, 4'd10}; low_thr = {4'd5, 4'd10};
                     rise_thr = {4'd4, 4'd11}; fall_thr = {4'd12, 4'd3}; end
            1: begin high_thr = {4'd7, 4'd7};  low_thr = {4'd2, 4'd13};
                     rise_thr = {4'd0, 4'd1};  fall_thr = {4'd15, 4'd14}; end
            2: begin high_thr = {4'd0, 4'd15}; low_thr = {4'd8, 4'd9};
                     rise_thr = {4'd7, 4'd8};  fall_thr = {4'd9, 4'd6}; end
            default: begin high_thr = {4'd3, 4'd12}; low_thr = {4'd6, 4'd6};
                     rise_thr = {4'd2, 4'd13}; fall_thr = {4'd10, 4'd1}; end
         endcase
         for (int i = 0; i < 1500; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            if (s[30:28] == 3'd0) irq_clr = s[27:24];
            if (s[15:9] == 7'd0) level_mode_en = ~level_mode_en;
            if (s[8:2] == 7'd1) edge_mode_en = ~edge_mode_en;
            if (s[3:0] == 4'd0) irq_en = s[7:4];
            step(s[19:16], s[20] | s[21]);
         end
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule